// File: doc/BRIEF.md
# Multiplexed VFD Grid Scanner

This block produces the time-multiplexed drive for a vacuum fluorescent display. It holds one 16-bit segment word per digit in an internal 11-word store and lights one digit (grid) at a time. While a grid is lit, the block presents that digit's segment word. A display clock enable (`tick_en`) advances the scan. Each grid slot lasts 16 ticks. A 3-bit mode code sets how many grids take part in the scan, from 4 to 11.

Five output lines have two roles. When the mode needs grids 7 to 11, the matching lines drive those grids. Otherwise they carry segments 12 to 16. A 3-bit dimming code sets how many ticks of each slot the display is lit. The first tick of every slot is always dark. A display-enable input blanks every output but leaves the scan running. At the end of each full scan the block raises `cycle_done_o` for one clock.

All outputs are registered. Each output reflects the scan position, the mode, the dimming code, the enable and the stored data as they were at the previous clock edge.

Top module: `vfd_scan_top`

## Requirements
- R1: While `rst_n` is low, and until the first scan clock after release, `seg_o`, `grid_o`, `dual_o` and `cycle_done_o` are all 0.
- R2: The number of active grids is N = mode + 4 (mode 0 gives 4 grids, mode 7 gives 11). The scan starts at grid index 0, tick 0. Each `tick_en` clock advances the tick, which runs 0..15. After tick 15 the grid index advances. After grid N-1 the grid index returns to 0. Dedicated line `grid_o[j]` drives grid index j (j = 0..5).
- R3: At most one dedicated grid line is high at any time.
- R4: Outputs are lit only on ticks 1..W. W is 1, 2, 4, 10, 11, 12, 13 or 14 for dimming codes 0 to 7. Ticks 0 and 15 are always fully dark.
- R5: While lit, `seg_o[i]` equals bit i of the stored word for the current grid index (i = 0..10).
- R6: Line `dual_o[k]` (k = 0..4) pairs segment bit 11+k with grid index 10-k. It acts as a grid, high for that grid index while lit, when N > 10-k. Otherwise it shows bit 11+k of the current word while lit.
- R7: When `disp_en` is low, every segment, grid and dual line is 0 on the next clock. The scan and `cycle_done_o` continue unchanged.
- R8: `cycle_done_o` pulses for exactly one clock when the scan leaves the last active grid's final tick. With a steady mode and `tick_en` held high, consecutive pulses are N*16 clocks apart.
- R9: When `tick_en` is low, the scan position does not change.
- R10: A write with `wr_en` high stores `wr_data` at `wr_addr` when the address is 0..10. Writes to addresses 11..15 change no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Display clock enable; one scan tick per enabled clock |
| mode | input | 3 | Grid-count code, N = mode + 4 |
| dim | input | 3 | Dimming code, 0 dimmest to 7 brightest |
| disp_en | input | 1 | Display enable; low blanks all drive lines |
| wr_en | input | 1 | Store write strobe |
| wr_addr | input | 4 | Digit word address |
| wr_data | input | 16 | Segment word, bit i is segment i+1 |
| seg_o | output | 11 | Dedicated segment lines |
| grid_o | output | 6 | Dedicated grid lines, grid indices 0..5 |
| dual_o | output | 5 | Shared segment/grid lines |
| cycle_done_o | output | 1 | One-clock end-of-scan pulse |

## Verification
The assertions check the following on every clock: the scan holds while the tick enable is low, and the grid index stays in range. At most one dedicated grid is lit. The slot-boundary tick and a low display enable always give dark outputs. The end-of-scan pulse lasts one clock and coincides with the scan position returning to zero. Only the bench scenarios can show the rest: the exact lit window for each dimming code, the grid-or-segment role of each shared line for each mode, the segment data read from the store, the spacing of the end-of-scan pulses, and the fact that out-of-range writes are dropped. The bench compares every output on every clock with an arithmetic model across all 64 mode and dimming combinations.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;

  // tick counter inside one grid slot
  localparam int unsigned TICK_W     = 4;
  localparam int unsigned SLOT_TICKS = 1 << TICK_W;

  // number of ticks lit within a slot for each dimming code
  function automatic logic [TICK_W-1:0] dim_on_len(input logic [2:0] code);
    logic [TICK_W-1:0] len;
    case (code)
      3'd0:    len = TICK_W'(1);
      3'd1:    len = TICK_W'(2);
      3'd2:    len = TICK_W'(4);
      3'd3:    len = TICK_W'(10);
      3'd4:    len = TICK_W'(11);
      3'd5:    len = TICK_W'(12);
      3'd6:    len = TICK_W'(13);
      default: len = TICK_W'(14);
    endcase
    return len;
  endfunction

  // active grid count for a mode code, clamped to the physical maximum
  function automatic int unsigned active_grids(input int unsigned code,
                                               input int unsigned min_g,
                                               input int unsigned max_g);
    int unsigned n;
    n = code + min_g;
    return (n > max_g) ? max_g : n;
  endfunction

endpackage

// File: rtl/vfd_rst_sync.sv
module vfd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sh_q[STAGES-1];

endmodule

// File: rtl/vfd_scan_ctr.sv
module vfd_scan_ctr
  import vfd_scan_pkg::*;
#(
  parameter int unsigned NGRID_MAX = 11,
  parameter int unsigned MIN_GRID  = 4,
  parameter int unsigned MODE_W    = 3,
  parameter int unsigned GIDX_W    = 4
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              tick_en,
  input  logic [MODE_W-1:0] mode,
  output logic [GIDX_W-1:0] grid_o,
  output logic [TICK_W-1:0] tick_o,
  output logic              cycle_done_o
);

  logic [GIDX_W-1:0] grid_q, grid_d;
  logic [TICK_W-1:0] tick_q, tick_d;
  logic              done_q, done_d;
  logic [GIDX_W-1:0] n_active;
  logic [GIDX_W-1:0] last_grid;
  logic              slot_end;

  always_comb begin
    n_active  = GIDX_W'(active_grids(int'(mode), MIN_GRID, NGRID_MAX));
    last_grid = n_active - GIDX_W'(1);
    slot_end  = (tick_q == '1);
  end

  // next-state logic
  always_comb begin
    grid_d = grid_q;
    tick_d = tick_q;
    done_d = 1'b0;
    if (tick_en) begin
      tick_d = tick_q + TICK_W'(1);
      if (slot_end) begin
        // also wraps a grid index left beyond range by a mode decrease
        if (grid_q >= last_grid) begin
          grid_d = '0;
          done_d = 1'b1;
        end else begin
          grid_d = grid_q + GIDX_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      grid_q <= '0;
      tick_q <= '0;
      done_q <= 1'b0;
    end else begin
      grid_q <= grid_d;
      tick_q <= tick_d;
      done_q <= done_d;
    end
  end

  assign grid_o       = grid_q;
  assign tick_o       = tick_q;
  assign cycle_done_o = done_q;

  // R9
  scan_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !tick_en |=> ($stable(grid_q) && $stable(tick_q)));

  // R2
  grid_range_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    grid_q < GIDX_W'(NGRID_MAX));

  // R8
  done_origin_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    done_q |-> (grid_q == '0 && tick_q == '0));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    done_q |=> !done_q);

endmodule

// File: rtl/vfd_dispmem.sv
module vfd_dispmem #(
  parameter int unsigned WORDS  = 11,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned AW     = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data
);

  logic [WORD_W-1:0] mem_q [WORDS];
  logic              wr_ok;
  logic              rd_ok;

  assign wr_ok = wr_en && (wr_addr < AW'(WORDS));
  assign rd_ok = (rd_addr < AW'(WORDS));

  // data storage only, no reset
  always_ff @(posedge clk) begin
    if (wr_ok) mem_q[wr_addr] <= wr_data;
  end

  assign rd_data = rd_ok ? mem_q[rd_addr] : '0;

endmodule

// File: rtl/vfd_out_mux.sv
module vfd_out_mux
  import vfd_scan_pkg::*;
#(
  parameter int unsigned SEG_DED  = 11,
  parameter int unsigned GRID_DED = 6,
  parameter int unsigned DUAL     = 5,
  parameter int unsigned MIN_GRID = 4,
  parameter int unsigned MODE_W   = 3,
  parameter int unsigned GIDX_W   = 4
) (
  input  logic                      clk,
  input  logic                      rst_ni,
  input  logic [GIDX_W-1:0]         grid_i,
  input  logic [TICK_W-1:0]         tick_i,
  input  logic [MODE_W-1:0]         mode,
  input  logic [2:0]                dim,
  input  logic                      disp_en,
  input  logic [SEG_DED+DUAL-1:0]   word_i,
  output logic [SEG_DED-1:0]        seg_o,
  output logic [GRID_DED-1:0]       grid_o,
  output logic [DUAL-1:0]           dual_o
);

  localparam int unsigned NGRID_MAX = GRID_DED + DUAL;

  logic [GIDX_W-1:0]   n_active;
  logic [TICK_W-1:0]   on_len;
  logic                lit;
  logic [SEG_DED-1:0]  seg_d,  seg_q;
  logic [GRID_DED-1:0] grid_d, grid_q;
  logic [DUAL-1:0]     dual_d, dual_q;
  logic [DUAL-1:0]     as_grid;

  always_comb begin
    n_active = GIDX_W'(active_grids(int'(mode), MIN_GRID, NGRID_MAX));
    on_len   = dim_on_len(dim);
    // tick 0 is the dark guard tick at every slot boundary
    lit      = disp_en && (tick_i != '0) && (tick_i <= on_len);
    seg_d    = lit ? word_i[SEG_DED-1:0] : '0;
  end

  for (genvar j = 0; j < GRID_DED; j++) begin : g_ded_grid
    assign grid_d[j] = lit && (grid_i == GIDX_W'(j));
  end

  // shared line k: segment SEG_DED+k or grid NGRID_MAX-1-k
  for (genvar k = 0; k < DUAL; k++) begin : g_dual
    localparam int unsigned GIDX = NGRID_MAX - 1 - k;
    localparam int unsigned SBIT = SEG_DED + k;
    assign as_grid[k] = (n_active > GIDX_W'(GIDX));
    assign dual_d[k]  = lit && (as_grid[k] ? (grid_i == GIDX_W'(GIDX))
                                           : word_i[SBIT]);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q  <= '0;
      grid_q <= '0;
      dual_q <= '0;
    end else begin
      seg_q  <= seg_d;
      grid_q <= grid_d;
      dual_q <= dual_d;
    end
  end

  assign seg_o  = seg_q;
  assign grid_o = grid_q;
  assign dual_o = dual_q;

  // R3
  one_grid_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(grid_q));

  // R4
  guard_dark_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (tick_i == '0) |=> (seg_q == '0 && grid_q == '0 && dual_q == '0));

  // R7
  blank_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !disp_en |=> (seg_q == '0 && grid_q == '0 && dual_q == '0));

endmodule

// File: rtl/vfd_scan_top.sv
module vfd_scan_top
  import vfd_scan_pkg::*;
#(
  parameter int unsigned SEG_DED  = 11,
  parameter int unsigned GRID_DED = 6,
  parameter int unsigned DUAL     = 5,
  parameter int unsigned MIN_GRID = 4,
  parameter int unsigned MODE_W   = 3,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick_en,
  input  logic [MODE_W-1:0]       mode,
  input  logic [2:0]              dim,
  input  logic                    disp_en,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [SEG_DED+DUAL-1:0] wr_data,
  output logic [SEG_DED-1:0]      seg_o,
  output logic [GRID_DED-1:0]     grid_o,
  output logic [DUAL-1:0]         dual_o,
  output logic                    cycle_done_o
);

  localparam int unsigned NGRID_MAX = GRID_DED + DUAL;
  localparam int unsigned WORD_W    = SEG_DED + DUAL;
  localparam int unsigned GIDX_W    = ADDR_W;

  logic              rst_i_n;
  logic [GIDX_W-1:0] scan_grid;
  logic [TICK_W-1:0] scan_tick;
  logic [WORD_W-1:0] cur_word;

  vfd_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_ni     (rst_n),
    .rst_sync_no(rst_i_n)
  );

  vfd_scan_ctr #(
    .NGRID_MAX(NGRID_MAX),
    .MIN_GRID (MIN_GRID),
    .MODE_W   (MODE_W),
    .GIDX_W   (GIDX_W)
  ) u_ctr (
    .clk         (clk),
    .rst_ni      (rst_i_n),
    .tick_en     (tick_en),
    .mode        (mode),
    .grid_o      (scan_grid),
    .tick_o      (scan_tick),
    .cycle_done_o(cycle_done_o)
  );

  vfd_dispmem #(
    .WORDS (NGRID_MAX),
    .WORD_W(WORD_W),
    .AW    (ADDR_W)
  ) u_mem (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_addr(scan_grid),
    .rd_data(cur_word)
  );

  vfd_out_mux #(
    .SEG_DED (SEG_DED),
    .GRID_DED(GRID_DED),
    .DUAL    (DUAL),
    .MIN_GRID(MIN_GRID),
    .MODE_W  (MODE_W),
    .GIDX_W  (GIDX_W)
  ) u_mux (
    .clk    (clk),
    .rst_ni (rst_i_n),
    .grid_i (scan_grid),
    .tick_i (scan_tick),
    .mode   (mode),
    .dim    (dim),
    .disp_en(disp_en),
    .word_i (cur_word),
    .seg_o  (seg_o),
    .grid_o (grid_o),
    .dual_o (dual_o)
  );

endmodule

// File: tb/sim_vfd_scan_top.sv
`timescale 1ns/1ps
module sim_vfd_scan_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ten;
  logic [2:0]  md, dm;
  logic        en;
  logic        we;
  logic [3:0]  wa;
  logic [15:0] wd;
  logic [10:0] seg_o;
  logic [5:0]  grid_o;
  logic [4:0]  dual_o;
  logic        cd_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model state
  int mg = 0;
  int mt = 0;
  logic [15:0] bmem [11];

  always #2.5 clk = ~clk;

  vfd_scan_top u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(ten), .mode(md), .dim(dm),
    .disp_en(en), .wr_en(we), .wr_addr(wa), .wr_data(wd),
    .seg_o(seg_o), .grid_o(grid_o), .dual_o(dual_o), .cycle_done_o(cd_o)
  );

  function automatic int ngrid(input int m);
    return (m + 4 > 11) ? 11 : m + 4;
  endfunction

  function automatic int onlen(input int d);
    case (d)
      0: return 1;  1: return 2;  2: return 4;  3: return 10;
      4: return 11; 5: return 12; 6: return 13; default: return 14;
    endcase
  endfunction

  // expected {dual, grid, seg}
  function automatic logic [21:0] exp_out(input int g, input int t, input int m,
                                          input int d, input bit e);
    logic [10:0] s;
    logic [5:0]  gr;
    logic [4:0]  du;
    bit on;
    on = e && (t >= 1) && (t <= onlen(d));
    s  = on ? bmem[g][10:0] : 11'd0;
    for (int j = 0; j < 6; j++) gr[j] = on && (g == j);
    for (int k = 0; k < 5; k++) begin
      if (ngrid(m) > 10 - k) du[k] = on && (g == 10 - k);
      else                   du[k] = on && bmem[g][11 + k];
    end
    return {du, gr, s};
  endfunction

  task automatic chk(input bit ok, input string req, input string ctx,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s (%s) actual=%h expected=%h t=%0t", req, ctx, act, exp, $time);
    end
  endtask

  task automatic step(input string ctx);
    int pg, pt, pm, pd, pwa;
    bit pen, pwe, cde;
    logic [15:0] pwd;
    logic [21:0] e;
    @(posedge clk);
    pg = mg; pt = mt; pm = int'(md); pd = int'(dm); pen = en;
    pwe = we; pwa = int'(wa); pwd = wd; cde = 0;
    if (ten) begin
      if (mt == 15) begin
        mt = 0;
        if (mg >= ngrid(pm) - 1) begin mg = 0; cde = 1; end
        else mg++;
      end else mt++;
    end
    @(negedge clk);
    e = exp_out(pg, pt, pm, pd, pen);
    chk(seg_o == e[10:0], "R5", ctx, 32'(seg_o), 32'(e[10:0]));
    chk(grid_o == e[16:11], "R2", ctx, 32'(grid_o), 32'(e[16:11]));
    chk(dual_o == e[21:17], "R6", ctx, 32'(dual_o), 32'(e[21:17]));
    chk(cd_o == cde, "R8", ctx, 32'(cd_o), 32'(cde));
    chk($countones(grid_o) <= 1, "R3", ctx, 32'(grid_o), 32'(e[16:11]));
    if (pt == 0 || pt == 15)
      chk({dual_o, grid_o, seg_o} == 22'd0, "R4", ctx, 32'({dual_o, grid_o, seg_o}), 32'd0);
    if (!pen)
      chk({dual_o, grid_o, seg_o} == 22'd0, "R7", ctx, 32'({dual_o, grid_o, seg_o}), 32'd0);
    if (pwe && pwa < 11) bmem[pwa] = pwd;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ten = 1'b1; md = 3'd0; dm = 3'd7; en = 1'b1;
    we = 1'b0; wa = '0; wd = '0;
    // R10: load the store while reset is held
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      we = 1'b1; wa = 4'(i);
      wd = 16'hA53C ^ 16'(i * 16'h1357) ^ 16'(i << 11);
      bmem[i] = wd;
    end
    @(negedge clk);
    we = 1'b0;
    // R1: reset state
    chk({dual_o, grid_o, seg_o, cd_o} == 23'd0, "R1", "reset", 32'({dual_o, grid_o, seg_o}), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk({dual_o, grid_o, seg_o, cd_o} == 23'd0, "R1", "sync release", 32'({dual_o, grid_o, cd_o}), 32'd0);
    @(posedge clk);
    @(negedge clk);
    // model starts in step with the first scanning edge

    // R2 R4 R5 R6: sweep every mode and dimming code
    for (int m = 0; m < 8; m++) begin
      for (int d = 0; d < 8; d++) begin
        md = 3'(m); dm = 3'(d);
        for (int s = 0; s < ngrid(m) * 16; s++) step("sweep");
      end
    end

    // R8: pulse spacing at steady mode, smallest and largest grid count
    for (int r = 0; r < 2; r++) begin
      int gap;
      md = (r == 0) ? 3'd0 : 3'd7;
      dm = 3'd3;
      while (!cd_o) step("R8 align");
      gap = 0;
      do begin step("R8 gap"); gap++; end while (!cd_o && gap < 400);
      chk(gap == ngrid(int'(md)) * 16, "R8", "pulse spacing", 32'(gap), 32'(ngrid(int'(md)) * 16));
    end

    // R7: blanked display, scan continues
    en = 1'b0; md = 3'd5;
    for (int s = 0; s < 200; s++) step("R7 blank");
    en = 1'b1;

    // R9: irregular tick enable
    md = 3'd6; dm = 3'd4;
    for (int s = 0; s < 500; s++) begin
      ten = ((s % 3) != 0) && ((s % 7) != 2);
      step("R9 gated");
    end
    ten = 1'b1;

    // R10: out-of-range writes, then in-range rewrite mid-scan
    md = 3'd7; dm = 3'd7;
    for (int a = 11; a < 16; a++) begin
      we = 1'b1; wa = 4'(a); wd = 16'hFFFF ^ 16'(a);
      step("R10 ignored write");
    end
    we = 1'b0;
    for (int s = 0; s < 11 * 16; s++) step("R10 after ignored");
    for (int i = 0; i < 11; i++) begin
      we = 1'b1; wa = 4'(i); wd = ~bmem[i] ^ 16'(i);
      step("R10 live write");
    end
    we = 1'b0;
    for (int s = 0; s < 11 * 16 + 16; s++) step("R10 after live");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule